// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host read and write an external, byte-wide asynchronous static RAM of 131,072 locations. The host presents one request at a time on a valid/ready handshake. The request carries an address, a write flag and write data. Read results come back on a separate one-cycle response strobe. On the memory side the controller drives the address, two chip selects of opposite polarity, an active-low write strobe and an active-low read (output) enable. It also drives the byte bus through its own drive-enable, which a pad tristate outside the block uses.

Every timing window is a whole number of clock cycles. The windows are the write strobe width, the full write cycle, the read access window and the bus release after a read. Each count is computed at elaboration time from a clock period parameter in nanoseconds and a speed-grade parameter. The fast grade needs a 35 ns strobe, a 55 ns write cycle, 55 ns access and 30 ns release. The slow grade needs 50, 70, 70 and 35 ns. Each count is the nanosecond figure divided by the period, rounded up, and never less than one. With the default 4 ns clock and the fast grade the counts are 9 strobe cycles, 14 access cycles and 8 release cycles, and the write recovery tail is 4 cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and just after it, the memory is deselected: ce_n = 1, ce = 0, we_n = 1, oe_n = 1, bus drive off, rsp_valid = 0, and req_ready = 1.
- R2: req_ready is 1 only when idle, and the memory is deselected whenever req_ready is 1. A request presented while req_ready is 0 is never carried out.
- R3: A write holds we_n low for exactly ceil(write-pulse ns / period) cycles (minimum 1). This is 9 cycles at the defaults.
- R4: During a write the controller drives the bus, with the request's data, for one cycle before we_n falls and for every cycle we_n is low. It releases the bus in the cycle we_n rises. The addressed location then holds that data.
- R5: A write keeps the controller busy for 1 + pulse + max(1, ceil(cycle ns / period) − pulse − 1) cycles after acceptance. This is 14 cycles at the defaults.
- R6: oe_n stays high during every write cycle. The bus drive is never on while oe_n is low.
- R7: A read holds oe_n low for ceil(access ns / period) cycles (14 at the defaults) and samples the bus at the end of the last of them. rsp_valid then pulses for exactly one cycle, in the cycle right after the window (the 15th busy cycle), with the sampled byte on rsp_rdata.
- R8: After a read the memory is deselected, with oe_n high, for ceil(release ns / period) cycles (minimum 1, 8 at the defaults) before req_ready returns. A read therefore occupies 22 busy cycles at the defaults, and a following write never starts without this gap.
- R9: sram_addr holds steady in every cycle where we_n is low. It takes the new request's full 17-bit address only while we_n is high.
- R10: The two chip selects always carry opposite levels: ce_n = ~ce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Byte read from memory |
| sram_addr | output | 17 | Memory address lines |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_ce | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low read output enable |
| sram_dq_out | output | 8 | Byte driven onto the bus |
| sram_dq_oe | output | 1 | Bus drive enable for the pad tristate |
| sram_dq_in | input | 8 | Byte seen on the bus |

## Verification
The bench's memory model returns garbage until the read condition has held for the full access window. A controller that samples even one cycle early therefore returns a wrong byte. The bench counts the cycles of each phase at the pins: strobe width, drive window, read enable, response position and total busy time. An off-by-one in any counter load shows up as a wrong count. The sequence includes a write right after a read, back-to-back reads, overwrites, and addresses at both ends of the range. It also stirs the request lines while the controller is busy and resets it in the middle of a read. A design that took a request early would corrupt a stored byte, and one that lagged on reset would leave the chip selected or the bus driven.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_WRECOV  = 3'd3,
    ST_RACCESS = 3'd4,
    ST_RTURN   = 3'd5
  } ctrl_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int WP_CYC  = 9,
  parameter int REC_CYC = 4,
  parameter int RD_CYC  = 14,
  parameter int TA_CYC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_done,
  output ctrl_state_e      state_q,
  output logic             accept,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             capture
);

  ctrl_state_e state_d;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          load   = 1'b1;
          if (req_write) begin
            state_d = ST_WSETUP;
          end else begin
            state_d  = ST_RACCESS;
            load_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        load     = 1'b1;
        load_val = CNT_W'(WP_CYC - 1);
      end
      ST_WPULSE: begin
        if (timer_done) begin
          state_d  = ST_WRECOV;
          load     = 1'b1;
          load_val = CNT_W'(REC_CYC - 1);
        end
      end
      ST_WRECOV: begin
        if (timer_done) state_d = ST_IDLE;
      end
      ST_RACCESS: begin
        if (timer_done) begin
          capture  = 1'b1;
          state_d  = ST_RTURN;
          load     = 1'b1;
          load_val = CNT_W'(TA_CYC - 1);
        end
      end
      ST_RTURN: begin
        if (timer_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sram_rdata_reg.sv
module sram_rdata_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter bit FAST_GRADE    = 1'b1,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned PULSE_NS   = FAST_GRADE ? 35 : 50;
  localparam int unsigned WCYCLE_NS  = FAST_GRADE ? 55 : 70;
  localparam int unsigned ACCESS_NS  = FAST_GRADE ? 55 : 70;
  localparam int unsigned OEVALID_NS = FAST_GRADE ? 30 : 40;
  localparam int unsigned RELEASE_NS = FAST_GRADE ? 30 : 35;

  localparam int WP_CYC  = int'(ns_to_cycles(PULSE_NS, CLK_PERIOD_NS));
  localparam int WC_CYC  = int'(ns_to_cycles(WCYCLE_NS, CLK_PERIOD_NS));
  localparam int RD_CYC  = int'(ns_to_cycles(umax(ACCESS_NS, OEVALID_NS), CLK_PERIOD_NS));
  localparam int TA_CYC  = int'(ns_to_cycles(RELEASE_NS, CLK_PERIOD_NS));
  localparam int REC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC - 1) : 1;
  localparam int MAX_CYC = int'(umax(umax(WP_CYC, REC_CYC), umax(RD_CYC, TA_CYC)));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  ctrl_state_e      state_q;
  logic             accept, load, capture, timer_done;
  logic [CNT_W-1:0] load_val;

  sram_seq_fsm #(
    .CNT_W  (CNT_W),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .RD_CYC (RD_CYC),
    .TA_CYC (TA_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_write (req_write),
    .timer_done(timer_done),
    .state_q   (state_q),
    .accept    (accept),
    .load      (load),
    .load_val  (load_val),
    .capture   (capture)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load    (load),
    .load_val(load_val),
    .done    (timer_done)
  );

  sram_rdata_reg #(.DATA_W(DATA_W)) u_rdata (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .capture(capture),
    .dq_in  (sram_dq_in),
    .rdata  (rsp_rdata),
    .valid  (rsp_valid)
  );

  // request latch, loaded only on acceptance (write strobe is high in idle)
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  logic selected;

  always_comb begin
    selected   = 1'b0;
    sram_we_n  = 1'b1;
    sram_oe_n  = 1'b1;
    sram_dq_oe = 1'b0;
    unique case (state_q)
      ST_WSETUP:  begin selected = 1'b1; sram_dq_oe = 1'b1; end
      ST_WPULSE:  begin selected = 1'b1; sram_dq_oe = 1'b1; sram_we_n = 1'b0; end
      ST_WRECOV:  begin selected = 1'b1; end
      ST_RACCESS: begin selected = 1'b1; sram_oe_n = 1'b0; end
      default:    begin selected = 1'b0; end
    endcase
  end

  assign sram_ce     = selected;
  assign sram_ce_n   = ~selected;
  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign req_ready   = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter bit FAST_GRADE    = 1'b1,
  parameter int ADDR_W        = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_ce,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);

  localparam int unsigned CHK_WP = ns_to_cycles(FAST_GRADE ? 35 : 50, CLK_PERIOD_NS);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          we_low_cnt <= '0;
    else if (!sram_we_n) we_low_cnt <= we_low_cnt + 16'd1;
    else                 we_low_cnt <= '0;
  end

  a_r10_ce_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n != sram_ce);

  a_r6_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  a_r6_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  a_r4_drive_during_we: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_dq_oe);

  a_r4_setup_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(sram_dq_oe));

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> $stable(sram_addr));

  a_r2_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && !sram_ce && sram_we_n && !sram_dq_oe));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_resp_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!sram_oe_n) && sram_oe_n));

  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we_n && $past(!sram_we_n)) |-> (we_low_cnt == 16'(CHK_WP)));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .FAST_GRADE   (FAST_GRADE),
  .ADDR_W       (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .sram_addr (sram_addr),
  .sram_ce_n (sram_ce_n),
  .sram_ce   (sram_ce),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  // expected counts at 4 ns, fast grade: ceil(35/4), ceil(55/4)-9-1, ceil(55/4), ceil(30/4)
  localparam int TB_WP  = 9;
  localparam int TB_REC = 4;
  localparam int TB_RD  = 14;
  localparam int TB_TA  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] sram_addr;
  logic        sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_out, sram_dq_in;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // memory model: 32 bytes indexed by the low address bits
  logic [7:0]  mem [0:31];
  logic [16:0] last_waddr;
  int          rd_age;
  logic        sel;

  assign sel = !sram_ce_n && sram_ce;
  assign sram_dq_in = (sel && sram_we_n && !sram_oe_n && rd_age >= TB_RD - 1)
                      ? mem[sram_addr[4:0]] : 8'hEE;

  always @(posedge clk) begin
    if (sel && !sram_we_n) begin
      mem[sram_addr[4:0]] <= sram_dq_out;
      last_waddr          <= sram_addr;
    end
    if (sel && sram_we_n && !sram_oe_n) rd_age <= rd_age + 1;
    else                                rd_age <= 0;
  end

  // pin monitor, sampled on the falling edge
  int v_r4 = 0, v_r6 = 0, v_r9 = 0, v_r10 = 0, v_r2 = 0;
  logic [16:0] prev_addr;
  logic        prev_we_n;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sram_we_n && !sram_dq_oe) v_r4++;
      if (sram_dq_oe && !sram_oe_n) v_r6++;
      if (!sram_we_n && !sram_oe_n) v_r6++;
      if ((!sram_we_n || !prev_we_n) && sram_addr != prev_addr) v_r9++;
      if (sram_ce_n == sram_ce) v_r10++;
      if (req_ready && (sel || !sram_we_n)) v_r2++;
    end
    prev_addr = sram_addr;
    prev_we_n = sram_we_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request with pin-level phase measurement
  task automatic run_op(input bit w, input logic [16:0] a, input logic [7:0] d,
                        input logic [7:0] exp, input bit poke);
    int busy = 0, we_low = 0, oe_low = 0, dq_cyc = 0, rv_cnt = 0, rv_at = 0;
    int setup_ok = 1;
    logic [7:0] got = 8'h00;
    logic       prev_dq = 1'b0;
    logic       prev_we = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 100) begin
      busy++;
      if (!sram_we_n) we_low++;
      if (!sram_oe_n) oe_low++;
      if (sram_dq_oe) dq_cyc++;
      if (!sram_we_n && prev_we && !prev_dq) setup_ok = 0;
      if (rsp_valid) begin rv_cnt++; rv_at = busy; got = rsp_rdata; end
      prev_dq = sram_dq_oe;
      prev_we = sram_we_n;
      if (poke && busy == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00001; req_wdata = 8'h99;
      end
      if (poke && busy == 6) req_valid = 1'b0;
      @(negedge clk);
    end
    if (rsp_valid) rv_cnt++;
    if (w) begin
      check(busy == 1 + TB_WP + TB_REC, "R5 write busy cycles", busy, 1 + TB_WP + TB_REC);
      check(we_low == TB_WP, "R3 write strobe cycles", we_low, TB_WP);
      check(dq_cyc == TB_WP + 1, "R4 bus drive cycles", dq_cyc, TB_WP + 1);
      check(setup_ok == 1, "R4 drive before strobe", setup_ok, 1);
      check(last_waddr == a, "R9 write address", int'(last_waddr), int'(a));
      check(oe_low == 0, "R6 oe during write", oe_low, 0);
    end else begin
      check(busy == TB_RD + TB_TA, "R8 read busy cycles", busy, TB_RD + TB_TA);
      check(oe_low == TB_RD, "R7 read enable cycles", oe_low, TB_RD);
      check(rv_cnt == 1, "R7 response pulses", rv_cnt, 1);
      check(rv_at == TB_RD + 1, "R7 response position", rv_at, TB_RD + 1);
      check(got == exp, "R7 read data", int'(got), int'(exp));
      check(dq_cyc == 0, "R6 drive during read", dq_cyc, 0);
    end
  endtask

  task automatic check_idle_pins(input string req);
    check(req_ready && sram_ce_n && !sram_ce && sram_we_n && sram_oe_n &&
          !sram_dq_oe && !rsp_valid, req,
          {req_ready, sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe, rsp_valid},
          7'b1101100);
  endtask

  // {write, address, data, expected read}
  localparam logic [33:0] VEC [9] = '{
    {1'b1, 17'h00001, 8'h55, 8'h00},
    {1'b1, 17'h1FFE2, 8'hAA, 8'h00},
    {1'b0, 17'h00001, 8'h00, 8'h55},
    {1'b1, 17'h1FFFF, 8'h0F, 8'h00},
    {1'b0, 17'h1FFE2, 8'h00, 8'hAA},
    {1'b0, 17'h1FFFF, 8'h00, 8'h0F},
    {1'b1, 17'h00001, 8'hC3, 8'h00},
    {1'b0, 17'h00001, 8'h00, 8'hC3},
    {1'b0, 17'h1FFFF, 8'h00, 8'h0F}
  };

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check_idle_pins("R1 pins in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle_pins("R1 pins after reset");

    for (int i = 0; i < 9; i++)
      run_op(VEC[i][33], VEC[i][32:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

    // R2: request lines toggled while busy; location 1 must keep C3
    run_op(1'b1, 17'h00005, 8'h3C, 8'h00, 1'b1);
    run_op(1'b0, 17'h00001, 8'h00, 8'hC3, 1'b0);
    run_op(1'b0, 17'h00005, 8'h00, 8'h3C, 1'b0);

    // R1: reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00005;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle_pins("R1 pins on mid-read reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle_pins("R1 pins after mid-read reset");
    run_op(1'b0, 17'h00005, 8'h00, 8'h3C, 1'b0);

    check(v_r4 == 0, "R4 strobe low without drive", v_r4, 0);
    check(v_r6 == 0, "R6 bus contention", v_r6, 0);
    check(v_r9 == 0, "R9 address moved near strobe", v_r9, 0);
    check(v_r10 == 0, "R10 chip select polarity", v_r10, 0);
    check(v_r2 == 0, "R2 selected while ready", v_r2, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

endmodule